// File: doc/BRIEF.md
# Load Queue Ordering Violation Detector

This block runs beside the circular load queue of an out-of-order core. It keeps a mirror of every in-flight load: whether the slot is live, whether the load's address is known yet, whether the load targets uncacheable space, its effective address and its sequence number. Loads are allocated at the tail, their addresses are written once computed, and they retire at the head.

When a load or a store executes, the detector scans the loads that are younger than it in program order. It looks for one that has already produced an address inside the same 256-byte block. Such a load ran ahead of an older memory access and may hold stale data. The detector reports the oldest such load, one cycle after the request, so that the pipeline can squash from that load and fetch it again. Uncacheable loads are never reported. They issue only once they are the oldest instruction in flight, so they cannot have passed anything.

Top module: `ldq_order_checker`

## Requirements
- R1: After reset, `viol_valid` is 0, `viol_idx` and `viol_seq` are 0, and the queue is empty, so an execute request reports nothing.
- R2: A queued load conflicts with the executing access when address bits [31:8] of both are equal. Addresses that differ only in bits [7:0] conflict. Addresses that differ in any of bits [31:8] do not.
- R3: A load whose address has not yet been written is never reported.
- R4: A load allocated with `alloc_uncached`=1 is never reported, even when its address matches. A younger cacheable match behind it is still reported.
- R5: `exec_kind` is 0 for a load and 1 for a store. For a load, the scan starts at the slot after `exec_pos`. For a store, `exec_pos` names the oldest load younger than the store, and the scan starts at that slot.
- R6: Only slots from the scan start up to, but not including, the tail are examined. Older loads and the executing load itself are never reported.
- R7: When several younger loads conflict, the one closest in age to the executing access is reported.
- R8: A violation appears as `viol_valid`=1 for exactly one cycle, in the cycle after the execute request, together with the slot index and sequence number of the violator. In every other cycle, `viol_idx` and `viol_seq` are 0.
- R9: When no younger load exists, nothing is reported. This is the case for a load at the last slot before the tail, or for a store whose position equals the tail.
- R10: Allocating a slot clears its address-known flag, so an address left behind by the slot's previous occupant cannot match.
- R11: The scan and the reported index follow the queue across the wrap from slot DEPTH-1 to slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate a load at the tail |
| alloc_uncached | input | 1 | The allocated load targets uncacheable space |
| alloc_seq | input | 16 | Sequence number of the allocated load |
| addr_valid_in | input | 1 | Write an effective address into a slot |
| addr_idx | input | 4 | Slot that receives the address |
| addr_value | input | 32 | Effective address |
| retire_valid | input | 1 | Retire the load at the head |
| exec_valid | input | 1 | An access executes this cycle |
| exec_kind | input | 1 | 0 = load, 1 = store |
| exec_pos | input | 4 | Load-queue position of the executing access |
| exec_addr | input | 32 | Effective address of the executing access |
| viol_valid | output | 1 | One-cycle violation pulse |
| viol_idx | output | 4 | Slot of the oldest violating load |
| viol_seq | output | 16 | Sequence number of the violating load |

## Verification
The bench builds the block with its default parameters: 16 slots, 32-bit addresses, 16-bit sequence numbers and a comparison granule that starts at bit 8. With 16 slots, a short run of allocate-and-retire steps moves the head to slot 14, so that a scan crosses the wrap. The same depth also lets the bench fill the queue completely, so that a full scan and the reuse of slots with stale addresses are both tested. The 8-bit granule offset means that addresses 0x80FF and 0x8000 must conflict, while 0x8800 and 0x8000 must not.

// File: rtl/ldq_ovd_pkg.sv
package ldq_ovd_pkg;
   typedef enum logic {
      KIND_LOAD  = 1'b0,
      KIND_STORE = 1'b1
   } exec_kind_e;
endpackage

// File: rtl/lq_entry_array.sv
module lq_entry_array #(
   parameter int DEPTH  = 16,
   parameter int ADDR_W = 32,
   parameter int SEQ_W  = 16,
   parameter int IDX_W  = 4
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          alloc_en,
   input  logic [IDX_W-1:0]              alloc_slot,
   input  logic                          alloc_unc,
   input  logic [SEQ_W-1:0]              alloc_seq,
   input  logic                          awr_en,
   input  logic [IDX_W-1:0]              awr_slot,
   input  logic [ADDR_W-1:0]             awr_addr,
   input  logic                          ret_en,
   input  logic [IDX_W-1:0]              ret_slot,
   output logic [DEPTH-1:0]              live,
   output logic [DEPTH-1:0]              known,
   output logic [DEPTH-1:0]              uncached,
   output logic [DEPTH-1:0][ADDR_W-1:0]  addr,
   output logic [DEPTH-1:0][SEQ_W-1:0]   seq
);
   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      localparam logic [IDX_W-1:0] SLOT = IDX_W'(i);
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            live[i]     <= 1'b0;
            known[i]    <= 1'b0;
            uncached[i] <= 1'b0;
            addr[i]     <= '0;
            seq[i]      <= '0;
         end else begin
            if (ret_en && ret_slot == SLOT) begin
               live[i]     <= 1'b0;
               known[i]    <= 1'b0;
               uncached[i] <= 1'b0;
            end
            if (alloc_en && alloc_slot == SLOT) begin
               live[i]     <= 1'b1;
               known[i]    <= 1'b0;
               uncached[i] <= alloc_unc;
               seq[i]      <= alloc_seq;
            end
            if (awr_en && awr_slot == SLOT && live[i]) begin
               known[i] <= 1'b1;
               addr[i]  <= awr_addr;
            end
         end
      end
   end
endmodule

// File: rtl/lq_conflict_match.sv
module lq_conflict_match #(
   parameter int DEPTH    = 16,
   parameter int ADDR_W   = 32,
   parameter int GRAN_LSB = 8,
   parameter int IDX_W    = 4,
   parameter int CNT_W    = 5
) (
   input  logic [DEPTH-1:0]              live,
   input  logic [DEPTH-1:0]              known,
   input  logic [DEPTH-1:0]              uncached,
   input  logic [DEPTH-1:0][ADDR_W-1:0]  addr,
   input  logic [ADDR_W-1:0]             probe_addr,
   input  logic [IDX_W-1:0]              head,
   input  logic [CNT_W-1:0]              occupancy,
   input  logic [CNT_W-1:0]              start_off,
   output logic [DEPTH-1:0]              hit_by_age
);
   for (genvar k = 0; k < DEPTH; k++) begin : g_age
      logic [IDX_W-1:0] slot;
      logic             in_window;
      logic             same_block;
      assign slot      = head + IDX_W'(k);
      assign in_window = (CNT_W'(k) >= start_off) && (CNT_W'(k) < occupancy);
      if (GRAN_LSB == 0) begin : g_exact
         assign same_block = addr[slot] == probe_addr;
      end else begin : g_block
         assign same_block = addr[slot][ADDR_W-1:GRAN_LSB] == probe_addr[ADDR_W-1:GRAN_LSB];
      end
      assign hit_by_age[k] = in_window && live[slot] && known[slot]
                             && !uncached[slot] && same_block;
   end
endmodule

// File: rtl/lq_oldest_pick.sv
module lq_oldest_pick #(
   parameter int DEPTH = 16,
   parameter int IDX_W = 4
) (
   input  logic [DEPTH-1:0] hit_by_age,
   output logic             any_hit,
   output logic [IDX_W-1:0] first_age
);
   always_comb begin
      first_age = '0;
      for (int k = DEPTH - 1; k >= 0; k--) begin
         if (hit_by_age[k]) first_age = IDX_W'(k);
      end
   end
   assign any_hit = |hit_by_age;
endmodule

// File: rtl/ldq_order_checker.sv
module ldq_order_checker #(
   parameter int DEPTH    = 16,
   parameter int ADDR_W   = 32,
   parameter int SEQ_W    = 16,
   parameter int GRAN_LSB = 8,
   localparam int IDX_W   = $clog2(DEPTH),
   localparam int CNT_W   = IDX_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alloc_valid,
   input  logic              alloc_uncached,
   input  logic [SEQ_W-1:0]  alloc_seq,
   input  logic              addr_valid_in,
   input  logic [IDX_W-1:0]  addr_idx,
   input  logic [ADDR_W-1:0] addr_value,
   input  logic              retire_valid,
   input  logic              exec_valid,
   input  logic              exec_kind,
   input  logic [IDX_W-1:0]  exec_pos,
   input  logic [ADDR_W-1:0] exec_addr,
   output logic              viol_valid,
   output logic [IDX_W-1:0]  viol_idx,
   output logic [SEQ_W-1:0]  viol_seq
);
   import ldq_ovd_pkg::*;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (GRAN_LSB < 0 || GRAN_LSB >= ADDR_W) begin : g_bad_gran
      $error("GRAN_LSB must lie inside the address");
   end

   logic [IDX_W-1:0] head_q, tail_q;
   logic [CNT_W-1:0] cnt_q;
   logic             do_ret, do_alloc;

   assign do_ret   = retire_valid && cnt_q != '0;
   assign do_alloc = alloc_valid && (cnt_q != CNT_W'(DEPTH) || do_ret);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head_q <= '0;
         tail_q <= '0;
         cnt_q  <= '0;
      end else begin
         if (do_ret)   head_q <= head_q + 1'b1;
         if (do_alloc) tail_q <= tail_q + 1'b1;
         cnt_q <= cnt_q + CNT_W'(do_alloc) - CNT_W'(do_ret);
      end
   end

   logic [DEPTH-1:0]             ent_live, ent_known, ent_unc;
   logic [DEPTH-1:0][ADDR_W-1:0] ent_addr;
   logic [DEPTH-1:0][SEQ_W-1:0]  ent_seq;

   lq_entry_array #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .SEQ_W(SEQ_W), .IDX_W(IDX_W)) u_entries (
      .clk(clk), .rst_n(rst_n),
      .alloc_en(do_alloc), .alloc_slot(tail_q), .alloc_unc(alloc_uncached), .alloc_seq(alloc_seq),
      .awr_en(addr_valid_in), .awr_slot(addr_idx), .awr_addr(addr_value),
      .ret_en(do_ret), .ret_slot(head_q),
      .live(ent_live), .known(ent_known), .uncached(ent_unc),
      .addr(ent_addr), .seq(ent_seq)
   );

   logic [IDX_W-1:0] exec_off;
   logic [CNT_W-1:0] start_off;
   assign exec_off  = exec_pos - head_q;
   assign start_off = {1'b0, exec_off} + ((exec_kind == KIND_STORE) ? CNT_W'(0) : CNT_W'(1));

   logic [DEPTH-1:0] hit_by_age;
   lq_conflict_match #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .GRAN_LSB(GRAN_LSB),
                       .IDX_W(IDX_W), .CNT_W(CNT_W)) u_match (
      .live(ent_live), .known(ent_known), .uncached(ent_unc), .addr(ent_addr),
      .probe_addr(exec_addr), .head(head_q), .occupancy(cnt_q), .start_off(start_off),
      .hit_by_age(hit_by_age)
   );

   logic             any_hit;
   logic [IDX_W-1:0] first_age, hit_slot;
   lq_oldest_pick #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_pick (
      .hit_by_age(hit_by_age), .any_hit(any_hit), .first_age(first_age)
   );
   assign hit_slot = head_q + first_age;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         viol_valid <= 1'b0;
         viol_idx   <= '0;
         viol_seq   <= '0;
      end else begin
         viol_valid <= exec_valid && any_hit;
         viol_idx   <= (exec_valid && any_hit) ? hit_slot : '0;
         viol_seq   <= (exec_valid && any_hit) ? ent_seq[hit_slot] : '0;
      end
   end

   // Checks: snapshot of slot flags as seen by the scan that produced a pulse
   logic [DEPTH-1:0] snap_known, snap_unc;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         snap_known <= '0;
         snap_unc   <= '0;
      end else begin
         snap_known <= ent_known;
         snap_unc   <= ent_unc;
      end
   end

   logic exec_youngest;
   assign exec_youngest = (exec_kind == KIND_STORE)
                          ? (exec_pos == tail_q && cnt_q != CNT_W'(DEPTH))
                          : (IDX_W'(exec_pos + 1'b1) == tail_q);

   p_pulse_after_exec_r8: assert property (@(posedge clk) disable iff (!rst_n)
      viol_valid |-> $past(exec_valid));
   p_quiet_outputs_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !viol_valid |-> (viol_idx == '0 && viol_seq == '0));
   p_known_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      viol_valid |-> snap_known[viol_idx]);
   p_skip_uncached_r4: assert property (@(posedge clk) disable iff (!rst_n)
      viol_valid |-> !snap_unc[viol_idx]);
   p_youngest_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_valid && exec_youngest) |=> !viol_valid);
   p_occupancy_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(DEPTH));
endmodule

// File: tb/sim_ldq_order_checker.sv
module sim_ldq_order_checker;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        alloc_valid, alloc_uncached, addr_valid_in, retire_valid;
   logic        exec_valid, exec_kind;
   logic [15:0] alloc_seq;
   logic [3:0]  addr_idx, exec_pos;
   logic [31:0] addr_value, exec_addr;
   logic        viol_valid;
   logic [3:0]  viol_idx;
   logic [15:0] viol_seq;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;
   int m_head = 0, m_tail = 0, m_cnt = 0;

   always #2 clk = ~clk;

   ldq_order_checker u0 (
      .clk(clk), .rst_n(rst_n),
      .alloc_valid(alloc_valid), .alloc_uncached(alloc_uncached), .alloc_seq(alloc_seq),
      .addr_valid_in(addr_valid_in), .addr_idx(addr_idx), .addr_value(addr_value),
      .retire_valid(retire_valid),
      .exec_valid(exec_valid), .exec_kind(exec_kind), .exec_pos(exec_pos), .exec_addr(exec_addr),
      .viol_valid(viol_valid), .viol_idx(viol_idx), .viol_seq(viol_seq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic idle();
      alloc_valid = 0; alloc_uncached = 0; alloc_seq = 0;
      addr_valid_in = 0; addr_idx = 0; addr_value = 0;
      retire_valid = 0; exec_valid = 0; exec_kind = 0; exec_pos = 0; exec_addr = 0;
   endtask

   task automatic alloc(input logic [15:0] s, input logic unc, output int slot);
      slot = m_tail;
      alloc_valid = 1; alloc_seq = s; alloc_uncached = unc;
      @(negedge clk); idle();
      m_tail = (m_tail + 1) % 16; m_cnt++;
   endtask

   task automatic set_addr(input int slot, input logic [31:0] a);
      addr_valid_in = 1; addr_idx = 4'(slot); addr_value = a;
      @(negedge clk); idle();
   endtask

   task automatic retire();
      retire_valid = 1;
      @(negedge clk); idle();
      m_head = (m_head + 1) % 16; m_cnt--;
   endtask

   task automatic drain();
      while (m_cnt > 0) retire();
   endtask

   task automatic exec(input logic kind, input int pos, input logic [31:0] a,
                       input logic hit, input int idx, input logic [15:0] s, input string tag);
      exec_valid = 1; exec_kind = kind; exec_pos = 4'(pos); exec_addr = a;
      @(negedge clk); idle();
      chk({tag, " pulse"}, 32'(viol_valid), 32'(hit));
      chk({tag, " idx"}, 32'(viol_idx), hit ? 32'(idx) : 32'd0);
      chk({tag, " seq"}, 32'(viol_seq), hit ? 32'(s) : 32'd0);
      @(negedge clk);
      chk({tag, " one-cycle"}, 32'(viol_valid), 32'd0);
   endtask

   task automatic t_reset();
      chk("R1 pulse", 32'(viol_valid), 0);
      chk("R1 idx", 32'(viol_idx), 0);
      chk("R1 seq", 32'(viol_seq), 0);
      exec(0, 0, 32'h0, 0, 0, 0, "R1 empty");
   endtask

   task automatic t_granule();
      int a, b;
      alloc(16'h100, 0, a); alloc(16'h101, 0, b);
      set_addr(a, 32'h1000); set_addr(b, 32'h10F0);
      exec(0, a, 32'h1000, 1, b, 16'h101, "R2 same block");
      set_addr(b, 32'h1100);
      exec(0, a, 32'h1000, 0, 0, 0, "R2 next block");
      drain();
   endtask

   task automatic t_addr_known();
      int a, b;
      alloc(16'h200, 0, a); alloc(16'h201, 0, b);
      set_addr(a, 32'h2000);
      exec(0, a, 32'h2000, 0, 0, 0, "R3 unknown addr");
      set_addr(b, 32'h2040);
      exec(0, a, 32'h2000, 1, b, 16'h201, "R3 known addr");
      drain();
   endtask

   task automatic t_uncached();
      int a, b, c;
      alloc(16'h300, 0, a); alloc(16'h301, 1, b); alloc(16'h302, 0, c);
      set_addr(a, 32'h3000); set_addr(b, 32'h3000); set_addr(c, 32'h3010);
      exec(0, a, 32'h3000, 1, c, 16'h302, "R4 skip uncached");
      exec(0, b, 32'h3000, 1, c, 16'h302, "R4 after uncached");
      drain();
   endtask

   task automatic t_store();
      int a, b;
      alloc(16'h400, 0, a); alloc(16'h401, 0, b);
      set_addr(b, 32'h4000);
      exec(1, b, 32'h4080, 1, b, 16'h401, "R5 store inclusive");
      exec(0, b, 32'h4080, 0, 0, 0, "R5 load exclusive");
      exec(0, a, 32'h4000, 1, b, 16'h401, "R5 load after pos");
      exec(1, m_tail, 32'h4000, 0, 0, 0, "R9 store at tail");
      drain();
   endtask

   task automatic t_window();
      int a, b, c;
      alloc(16'h500, 0, a); alloc(16'h501, 0, b); alloc(16'h502, 0, c);
      set_addr(a, 32'h5000); set_addr(b, 32'h5000); set_addr(c, 32'h5000);
      exec(0, b, 32'h5000, 1, c, 16'h502, "R6 older skipped");
      exec(0, c, 32'h5000, 0, 0, 0, "R9 youngest load");
      drain();
   endtask

   task automatic t_oldest();
      int a, b, c, d;
      alloc(16'h600, 0, a); alloc(16'h601, 0, b); alloc(16'h602, 0, c); alloc(16'h603, 0, d);
      set_addr(b, 32'h7100); set_addr(c, 32'h7000); set_addr(d, 32'h7000);
      exec(0, a, 32'h7000, 1, c, 16'h602, "R7 oldest match");
      drain();
   endtask

   task automatic t_wrap();
      int a, b, c, dummy;
      while (m_tail != 14) begin
         alloc(16'h0, 0, dummy); retire();
      end
      alloc(16'h700, 0, a); alloc(16'h701, 0, b); alloc(16'h702, 0, c);
      set_addr(b, 32'h8800); set_addr(c, 32'h80FF);
      chk("R11 slot at wrap", 32'(c), 0);
      exec(0, a, 32'h8000, 1, c, 16'h702, "R11 wrap scan");
      drain();
   endtask

   task automatic t_full_and_stale();
      int slots[16];
      int x, y;
      for (int i = 0; i < 16; i++) alloc(16'(16'h900 + i), 0, slots[i]);
      for (int i = 1; i < 16; i++) set_addr(slots[i], 32'hC000);
      exec(0, slots[0], 32'hC000, 1, slots[1], 16'h901, "R7 full queue");
      exec(0, slots[14], 32'hC000, 1, slots[15], 16'h90F, "R6 full tail");
      exec(0, slots[15], 32'hC000, 0, 0, 0, "R9 full youngest");
      drain();
      alloc(16'hA00, 0, x); alloc(16'hA01, 0, y);
      set_addr(x, 32'hC000);
      exec(0, x, 32'hC000, 0, 0, 0, "R10 stale address");
      drain();
   endtask

   initial begin
      idle();
      rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_granule();
      t_addr_known();
      t_uncached();
      t_store();
      t_window();
      t_oldest();
      t_wrap();
      t_full_and_stale();
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         checks++; failures++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule